// File: doc/BRIEF.md
# Run-Length Capture Stream Expander

This block turns a compressed capture stream back into one sample per output transfer. Each input word is WORD_W bits wide. When the top bit is clear, the word carries a fresh sample in its lower bits. When the top bit is set, the word says how many more times the last sample occurred. The compressor that builds such streams never puts two count words next to each other. Its counts stop at the all-ones value instead of wrapping.

Words come in on a valid/ready handshake. Expanded samples leave on a second valid/ready handshake, each paired with a running index. A count word is expanded one copy per accepted output transfer. Input ready is held low for the whole expansion, so backpressure from the consumer reaches the producer directly. Two sticky flags report malformed streams: a count word with no sample before it, and two count words in a row. Both flags hold until reset.

Top module: `rle_stream_expander`

## Requirements
- R1: An accepted word with bit WORD_W-1 clear is a sample word. Its bits WORD_W-2:0 are presented on out_sample exactly once, and that value becomes the held sample.
- R2: An accepted word with bit WORD_W-1 set is a count word with count N in bits WORD_W-2:0. It produces exactly N further copies of the held sample. N = 0 produces no output.
- R3: An all-ones count is an ordinary run of 2^(WORD_W-1)-1 copies and carries no special meaning.
- R4: A count word accepted while no sample has been seen since reset is dropped without any output, and it sets err_lead_run. The flag stays set until reset.
- R5: A count word accepted directly after another accepted count word sets err_double_run, which stays set until reset. The word is still expanded normally.
- R6: While copies of a run are still pending, in_ready is low. It goes high only in the cycle in which the last copy is accepted downstream. in_ready is never high while a presented output is stalled.
- R7: out_index is 0 after reset and increases by exactly one for each accepted output transfer (out_valid and out_ready both high). Otherwise it does not change.
- R8: While out_valid is high and out_ready is low, out_valid, out_sample and out_index stay unchanged, and no pending copy is used up.
- R9: Reset clears out_valid, out_index, both error flags and the held sample. A count word arriving first after reset is therefore handled as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_word | input | WORD_W | Compressed word: top bit = count flag, rest = sample or count |
| out_valid | output | 1 | Expanded sample valid |
| out_ready | input | 1 | Consumer accepts the sample |
| out_sample | output | WORD_W-1 | Expanded sample value |
| out_index | output | IDX_W | Index of the presented sample since reset |
| err_lead_run | output | 1 | Sticky: count word arrived with no sample before it |
| err_double_run | output | 1 | Sticky: two count words in a row |

## Verification
The bench drives random sample sequences through a reference compressor and compares the expanded output, value by value and index by index. This finds a run that is off by one copy, which shows up as a shifted index, and it finds repeats taken from the wrong value. A full all-ones count is expanded with random stalls and must yield exactly one plus the maximum copies. A design that treats that count as a special code, or one that loses copies while stalled, returns the wrong length. Other tests use a leading count word, a count word after reset, two count words in a row, and a zero count. A design that repeats an invalid sample, forgets to clear the held sample at reset, or drops the second run gives the wrong stream or the wrong flags. A cycle-by-cycle check of in_ready during a run catches a handshake that reopens early and would lose or overlap words.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
  // Meaning of the top bit of a compressed word
  typedef enum logic [0:0] {
    WK_SAMPLE = 1'b0,
    WK_RUN    = 1'b1
  } word_kind_e;
endpackage

// File: rtl/rlx_word_decode.sv
module rlx_word_decode
  import rlx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int PAY_W = WORD_W - 1
) (
  input  logic [WORD_W-1:0] in_word,
  output word_kind_e        kind,
  output logic [PAY_W-1:0]  payload
);
  // The top bit selects the word class, the rest is value or count
  assign kind    = word_kind_e'(in_word[WORD_W-1]);
  assign payload = in_word[PAY_W-1:0];
endmodule

// File: rtl/rlx_run_ctrl.sv
module rlx_run_ctrl
  import rlx_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  word_kind_e       kind,
  input  logic [CNT_W-1:0] count,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             load_new,
  output logic             load_rep,
  output logic             err_lead,
  output logic             err_double
);
  logic [CNT_W-1:0] rem_q;       // copies not yet loaded into the output slot
  logic             have_q;      // a sample has been seen since reset
  logic             last_run_q;  // previous accepted word was a count word
  logic             take, is_run, run_ok, pending, zero_cnt;

  assign pending  = (rem_q != '0);
  assign in_ready = !pending && slot_free;
  assign take     = in_valid && in_ready;
  assign is_run   = (kind == WK_RUN);
  assign zero_cnt = (count == '0);
  assign run_ok   = take && is_run && have_q;
  assign load_new = take && !is_run;
  assign load_rep = (pending && slot_free) || (run_ok && !zero_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q      <= '0;
      have_q     <= 1'b0;
      last_run_q <= 1'b0;
      err_lead   <= 1'b0;
      err_double <= 1'b0;
    end else begin
      // A copy is used up only when the output slot can take it
      if (pending && slot_free)
        rem_q <= rem_q - 1'b1;
      else if (run_ok && !zero_cnt)
        rem_q <= count - 1'b1;

      if (take) begin
        if (!is_run) begin
          have_q     <= 1'b1;
          last_run_q <= 1'b0;
        end else if (!have_q) begin
          err_lead <= 1'b1;
        end else begin
          if (last_run_q)
            err_double <= 1'b1;
          last_run_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rlx_out_stage.sv
module rlx_out_stage #(
  parameter int SAMP_W = 31,
  parameter int IDX_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_new,
  input  logic              load_rep,
  input  logic [SAMP_W-1:0] new_sample,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [SAMP_W-1:0] out_sample,
  output logic [IDX_W-1:0]  out_index
);
  logic [SAMP_W-1:0] held_q;

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_index  <= '0;
      held_q     <= '0;
    end else begin
      if (out_valid && out_ready)
        out_index <= out_index + 1'b1;
      if (load_new) begin
        out_sample <= new_sample;
        held_q     <= new_sample;
        out_valid  <= 1'b1;
      end else if (load_rep) begin
        out_sample <= held_q;
        out_valid  <= 1'b1;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rle_stream_expander.sv
module rle_stream_expander
  import rlx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 32,
  localparam int SAMP_W = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SAMP_W-1:0] out_sample,
  output logic [IDX_W-1:0]  out_index,
  output logic              err_lead_run,
  output logic              err_double_run
);
  word_kind_e        kind;
  logic [SAMP_W-1:0] payload;
  logic              slot_free, load_new, load_rep;

  rlx_word_decode #(.WORD_W(WORD_W)) u_decode (
    .in_word (in_word),
    .kind    (kind),
    .payload (payload)
  );

  rlx_run_ctrl #(.CNT_W(SAMP_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .kind       (kind),
    .count      (payload),
    .slot_free  (slot_free),
    .in_ready   (in_ready),
    .load_new   (load_new),
    .load_rep   (load_rep),
    .err_lead   (err_lead_run),
    .err_double (err_double_run)
  );

  rlx_out_stage #(.SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .load_new   (load_new),
    .load_rep   (load_rep),
    .new_sample (payload),
    .out_ready  (out_ready),
    .slot_free  (slot_free),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .out_index  (out_index)
  );
endmodule

// File: rtl/rle_stream_expander_chk.sv
module rle_stream_expander_chk #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 32,
  localparam int SAMP_W = WORD_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SAMP_W-1:0] out_sample,
  input logic [IDX_W-1:0]  out_index,
  input logic              err_lead_run,
  input logic              err_double_run
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_index))); // R8

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (out_index == $past(out_index) + IDX_W'(1))); // R7

  AST_INDEX_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_ready) |=> $stable(out_index)); // R7

  AST_READY_NEEDS_SLOT: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!out_valid || out_ready)); // R6

  AST_LEAD_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_lead_run |=> err_lead_run); // R4

  AST_DOUBLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_double_run |=> err_double_run); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_index == '0 && !err_lead_run && !err_double_run)); // R9
endmodule

bind rle_stream_expander rle_stream_expander_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_rle_stream_expander.sv
`timescale 1ns/100ps
module test_rle_stream_expander;
  localparam int WW   = 12;
  localparam int SW   = WW - 1;
  localparam int IW   = 32;
  localparam int MAXC = (1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [WW-1:0] in_word = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_sample;
  logic [IW-1:0] out_index;
  logic          err_lead_run, err_double_run;

  int tests = 0;
  int fails = 0;
  int mode  = 0;  // 0: ready always, 1: random ready, 2: ready held low

  logic [SW-1:0] got_s[$];
  int            got_i[$];
  logic [SW-1:0] exp_q[$];

  rle_stream_expander #(.WORD_W(WW), .IDX_W(IW)) i_rle_stream_expander (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .out_index(out_index),
    .err_lead_run(err_lead_run), .err_double_run(err_double_run)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (mode == 0) out_ready = 1'b1;
    else if (mode == 2) out_ready = 1'b0;
    else out_ready = ($urandom_range(0, 3) != 0);
  end

  // Record accepted output transfers just before the edge that takes them
  always begin
    @(negedge clk);
    #2;
    if (!rst && out_valid && out_ready) begin
      got_s.push_back(out_sample);
      got_i.push_back(int'(out_index));
    end
  end

  function automatic logic [WW-1:0] mk_samp(input int v);
    return {1'b0, SW'(v)};
  endfunction
  function automatic logic [WW-1:0] mk_run(input int n);
    return {1'b1, SW'(n)};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Called at a falling edge, returns at a falling edge
  task automatic send(input logic [WW-1:0] w);
    in_valid = 1'b1;
    in_word  = w;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int quiet = 0;
    int guard = 0;
    while (quiet < 4 && guard < 20000) begin
      @(negedge clk);
      #2;
      if (!out_valid && in_ready) quiet++; else quiet = 0;
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    got_s.delete();
    got_i.delete();
    exp_q.delete();
  endtask

  task automatic check_stream(input string tag);
    int bad = 0;
    int first = -1;
    chk(got_s.size() == exp_q.size(), {tag, " stream length"}, got_s.size(), exp_q.size());
    for (int k = 0; k < got_s.size() && k < exp_q.size(); k++) begin
      if (got_s[k] !== exp_q[k] || got_i[k] != k) begin
        bad++;
        if (first < 0) first = k;
      end
    end
    if (bad != 0)
      chk(1'b0, {tag, " stream value/index at first bad position"},
          (first >= 0) ? longint'(got_s[first]) : 0, (first >= 0) ? longint'(exp_q[first]) : 0);
    else
      chk(1'b1, {tag, " stream content"}, 0, 0);
  endtask

  // R9: state right after reset
  task automatic t_reset_state();
    do_reset();
    #2;
    chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    chk(out_index == '0, "R9 out_index after reset", out_index, 0);
    chk(!err_lead_run && !err_double_run, "R9 error flags after reset",
        {err_lead_run, err_double_run}, 0);
    chk(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
    @(negedge clk);
  endtask

  // R1 R2 R7: samples, a run, a zero run
  task automatic t_basic();
    do_reset();
    mode = 0;
    @(negedge clk);
    send(mk_samp(100)); send(mk_run(3)); send(mk_samp(200)); send(mk_run(0)); send(mk_samp(300));
    drain();
    exp_q = '{11'd100, 11'd100, 11'd100, 11'd100, 11'd200, 11'd300};
    check_stream("R1 R2 R7 basic");
    chk(!err_lead_run && !err_double_run, "R2 zero run raises no flag",
        {err_lead_run, err_double_run}, 0);
  endtask

  // R1 R2 R8: random sequences through a reference compressor, random stalls
  task automatic t_random();
    logic [SW-1:0] seq[$];
    logic [WW-1:0] words[$];
    logic [SW-1:0] prev;
    int cnt;
    bit have;
    do_reset();
    mode = 1;
    prev = '0;
    for (int i = 0; i < 300; i++) begin
      if (i != 0 && $urandom_range(0, 2) != 0) seq.push_back(prev);
      else seq.push_back(SW'($urandom_range(0, MAXC)));
      prev = seq[i];
    end
    have = 1'b0; cnt = 0;
    foreach (seq[i]) begin
      if (have && seq[i] == prev && cnt < MAXC) cnt++;
      else begin
        if (cnt > 0) words.push_back(mk_run(cnt));
        words.push_back(mk_samp(int'(seq[i])));
        prev = seq[i]; have = 1'b1; cnt = 0;
      end
    end
    if (cnt > 0) words.push_back(mk_run(cnt));
    @(negedge clk);
    foreach (words[i]) send(words[i]);
    drain();
    exp_q = seq;
    check_stream("R1 R2 R8 random round trip");
    chk(!err_lead_run && !err_double_run, "R1 no flags on a valid stream",
        {err_lead_run, err_double_run}, 0);
  endtask

  // R3: all-ones count under random stalls
  task automatic t_saturated();
    do_reset();
    mode = 1;
    @(negedge clk);
    send(mk_samp(933)); send(mk_run(MAXC)); send(mk_samp(17));
    drain();
    for (int k = 0; k <= MAXC; k++) exp_q.push_back(11'd933);
    exp_q.push_back(11'd17);
    check_stream("R3 saturated count");
  endtask

  // R6: in_ready during a run
  task automatic t_ready_timing();
    int acc = 0;
    int bad = 0;
    int guard = 0;
    bit done = 1'b0;
    bit will;
    do_reset();
    mode = 1;
    @(negedge clk);
    send(mk_samp(5)); send(mk_run(4));
    while (!done && guard < 200) begin
      #2;
      will = out_valid && out_ready;
      if (in_ready !== (will && acc == 3)) bad++;
      if (will) acc++;
      if (acc == 4) done = 1'b1;
      @(negedge clk);
      guard++;
    end
    chk(bad == 0, "R6 in_ready low until last copy accepted", bad, 0);
    chk(acc == 4, "R6 copies seen during run", acc, 4);
    drain();
    exp_q = '{11'd5, 11'd5, 11'd5, 11'd5, 11'd5};
    check_stream("R2 R6 run of four");
  endtask

  // R8: long stall keeps output and consumes nothing
  task automatic t_stall();
    logic [SW-1:0] s0;
    logic [IW-1:0] i0;
    int bad = 0;
    do_reset();
    mode = 0;
    @(negedge clk);
    send(mk_samp(77)); send(mk_run(5));
    mode = 2; out_ready = 1'b0;
    #2;
    s0 = out_sample; i0 = out_index;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk); #2;
      if (!out_valid || out_sample !== s0 || out_index !== i0 || in_ready) bad++;
    end
    chk(bad == 0, "R8 output stable while stalled", bad, 0);
    @(negedge clk);
    mode = 0; out_ready = 1'b1;
    drain();
    exp_q = '{11'd77, 11'd77, 11'd77, 11'd77, 11'd77, 11'd77};
    check_stream("R8 no copy lost in stall");
  endtask

  // R4: count word first after reset
  task automatic t_leading_run();
    do_reset();
    mode = 0;
    @(negedge clk);
    send(mk_run(5));
    repeat (3) @(negedge clk);
    #2;
    chk(got_s.size() == 0 && !out_valid, "R4 leading run gives no output", got_s.size(), 0);
    chk(err_lead_run == 1'b1, "R4 lead flag set", err_lead_run, 1);
    @(negedge clk);
    send(mk_samp(42));
    drain();
    exp_q = '{11'd42};
    check_stream("R4 stream after dropped run");
    chk(err_lead_run == 1'b1, "R4 lead flag sticky", err_lead_run, 1);
    chk(err_double_run == 1'b0, "R4 dropped run not a double", err_double_run, 0);
  endtask

  // R5: two count words in a row
  task automatic t_double_run();
    do_reset();
    mode = 1;
    @(negedge clk);
    send(mk_samp(9)); send(mk_run(2)); send(mk_run(3));
    drain();
    exp_q = '{11'd9, 11'd9, 11'd9, 11'd9, 11'd9, 11'd9};
    check_stream("R5 second run still expanded");
    chk(err_double_run == 1'b1, "R5 double flag set", err_double_run, 1);
    chk(err_lead_run == 1'b0, "R5 lead flag clear", err_lead_run, 0);
  endtask

  // R9: reset forgets the held sample
  task automatic t_reset_forgets();
    do_reset();
    mode = 0;
    @(negedge clk);
    send(mk_samp(321));
    drain();
    do_reset();
    #2;
    chk(out_index == '0 && !out_valid, "R9 index cleared by reset", out_index, 0);
    @(negedge clk);
    send(mk_run(2));
    drain();
    chk(got_s.size() == 0, "R9 held sample cleared by reset", got_s.size(), 0);
    chk(err_lead_run == 1'b1, "R9 run after reset flagged", err_lead_run, 1);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_basic();
    t_random();
    t_saturated();
    t_ready_timing();
    t_stall();
    t_leading_run();
    t_double_run();
    t_reset_forgets();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule